// File: doc/BRIEF.md
# Password-Protected Clock Gate Bank

This block is a small register bank that owns a set of peripheral clock enables. Each gate can be driven by a hardware request line or by a software enable bit. A select bit chooses the source. The block reports every gate's real state through a read-only status bit. That bit rises a fixed number of cycles after the enable opens. When hysteresis is on, a gate that loses its request stays open for a short or a long hold time before it closes.

Software cannot change the bank by accident. Every register other than the access register is write-protected. Software first writes a 16-bit key together with an open/close bit to word address 0. A write that breaks this rule is thrown away and sets a sticky violation flag. Gates can be built as "never off": under software control such a gate stays open, and its enable bit always reads back 0.

The bus is a single-cycle word-addressed write strobe with a combinational read port. The enable outputs are plain level signals meant for downstream clock-gating cells.

Top module: `ccg_bank`

## Requirements
- R1: A write to word address 0 whose bits 23:8 equal the key 0xA5A5 sets the write-open state from bit 0 (1 opens, 0 closes). Reading address 0 returns the open state in bit 0 and the violation flag in bit 1.
- R2: Reads are served at every address whatever the open state. Gate i lives at word address i+1 with enable in bit 0, source select in bit 1 and read-only status in bit 2. The hysteresis register lives at address NUM_GATES+1 with hysteresis-on in bit 0 and long-hold in bit 1. Unmapped addresses read 0.
- R3: A write to a gate or hysteresis register while the bank is closed changes nothing and sets the violation flag. The flag stays set until reset.
- R4: A write to address 0 whose key field is not 0xA5A5 leaves the open state unchanged and sets the violation flag.
- R5: With select = 0 the gate follows the hwReq input and the enable bit has no effect.
- R6: With select = 1 the gate follows the enable bit. clkEn rises on the clock edge after the request appears, and the status bit rises ON_LAT cycles after clkEn.
- R7: A gate marked in NO_DISABLE reads its enable bit as 0 even after a 1 is written. Under software control it stays open whatever the enable bit holds.
- R8: With hysteresis off, clkEn and status fall together on the clock edge after the request is removed.
- R9: With hysteresis on and long-hold 0, clkEn and status stay high SHORT_DLY cycles longer than without hysteresis.
- R10: With hysteresis on and long-hold 1, the extra hold is LONG_DLY cycles.
- R11: A request that returns during the hold keeps the gate open and its status never drops. A request withdrawn before the turn-on latency ends closes the gate without the status ever rising.
- R12: After reset the bank is closed, the violation flag is clear, all gate and hysteresis bits are 0 (hardware source), and no gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Word address for read and write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| hwReq | input | NUM_GATES | Hardware request per gate |
| clkEn | output | NUM_GATES | Clock enable per gate |
| gateStatus | output | NUM_GATES | Settled-open status per gate |

## Verification
Gates are driven from both sources. A hardware request is toggled with the enable bit set, which shows that the select really picks the source. Turn-off is tried three ways: without hysteresis, with the short hold and with the long hold. The exact fall cycle separates the three hold lengths. Two race cases are also run: a request that comes back inside the hold, and an enable that is withdrawn inside the turn-on latency. These catch a design that restarts or skips phases. Writes are issued while closed, with a bad key, and to a never-off gate. Each is read back so that a dropped write can be told apart from an accepted one.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [1:0] {
    GATE_OFF,
    GATE_RISE,
    GATE_ON,
    GATE_FALL
  } gatePhase_t;

  typedef struct packed {
    logic gateWr;
    logic hystWr;
  } regStrobe_t;

endpackage

// File: rtl/ccg_gate.sv
module ccg_gate
  import ccg_pkg::*;
#(
  parameter int ON_LAT    = 2,
  parameter int SHORT_DLY = 16,
  parameter int LONG_DLY  = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  input  logic hystEn,
  input  logic hystLong,
  output logic clkEn,
  output logic status
);

  localparam int MAX_A = (ON_LAT > SHORT_DLY) ? ON_LAT : SHORT_DLY;
  localparam int MAX_DLY = (MAX_A > LONG_DLY) ? MAX_A : LONG_DLY;
  localparam int CNT_W = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] ON_LOAD    = CNT_W'(ON_LAT - 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_DLY - 1);

  gatePhase_t phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= GATE_OFF;
      cnt   <= '0;
    end else begin
      case (phase)
        GATE_OFF: begin
          if (req) begin
            phase <= GATE_RISE;
            cnt   <= ON_LOAD;
          end
        end
        GATE_RISE: begin
          if (!req) phase <= GATE_OFF;
          else if (cnt == '0) phase <= GATE_ON;
          else cnt <= cnt - 1'b1;
        end
        GATE_ON: begin
          if (!req) begin
            if (hystEn) begin
              phase <= GATE_FALL;
              cnt   <= hystLong ? LONG_LOAD : SHORT_LOAD;
            end else begin
              phase <= GATE_OFF;
            end
          end
        end
        default: begin
          if (req) phase <= GATE_ON;
          else if (cnt == '0) phase <= GATE_OFF;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign clkEn  = (phase != GATE_OFF);
  assign status = (phase == GATE_ON) || (phase == GATE_FALL);

endmodule

// File: rtl/ccg_ctrl.sv
module ccg_ctrl
  import ccg_pkg::*;
#(
  parameter int          NUM_GATES = 4,
  parameter int          ADDR_W    = 4,
  parameter logic [15:0] PASSWORD  = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output regStrobe_t        strobe,
  output logic              accessOpen,
  output logic              violation
);

  localparam logic [ADDR_W-1:0] LAST_GATE = ADDR_W'(NUM_GATES);
  localparam logic [ADDR_W-1:0] HYST_ADDR = ADDR_W'(NUM_GATES + 1);

  logic isAccess, isGate, isHyst, isProt, keyOk;

  assign isAccess = (busAddr == '0);
  assign isGate   = (busAddr != '0) && (busAddr <= LAST_GATE);
  assign isHyst   = (busAddr == HYST_ADDR);
  assign isProt   = isGate || isHyst;
  assign keyOk    = (busWdata[23:8] == PASSWORD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessOpen <= 1'b0;
      violation  <= 1'b0;
    end else if (busWr) begin
      if (isAccess && keyOk) accessOpen <= busWdata[0];
      if ((isAccess && !keyOk) || (isProt && !accessOpen)) violation <= 1'b1;
    end
  end

  assign strobe.gateWr = busWr && isGate && accessOpen;
  assign strobe.hystWr = busWr && isHyst && accessOpen;

endmodule

// File: rtl/ccg_regs.sv
module ccg_regs
  import ccg_pkg::*;
#(
  parameter int                   NUM_GATES  = 4,
  parameter int                   ADDR_W     = 4,
  parameter int                   ON_LAT     = 2,
  parameter int                   SHORT_DLY  = 16,
  parameter int                   LONG_DLY   = 64,
  parameter logic [NUM_GATES-1:0] NO_DISABLE = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  input  logic                 accessOpen,
  input  logic                 violation,
  input  logic [NUM_GATES-1:0] hwReq,
  output logic [31:0]          busRdata,
  output logic [NUM_GATES-1:0] clkEn,
  output logic [NUM_GATES-1:0] gateStatus
);

  localparam logic [ADDR_W-1:0] HYST_ADDR = ADDR_W'(NUM_GATES + 1);

  logic [NUM_GATES-1:0] swEn, swSel, gateReq;
  logic hystEn, hystLong;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hystEn   <= 1'b0;
      hystLong <= 1'b0;
    end else if (strobe.hystWr) begin
      hystEn   <= busWdata[0];
      hystLong <= busWdata[1];
    end
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : gGate
    logic wrThis;
    assign wrThis = strobe.gateWr && (busAddr == ADDR_W'(g + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swEn[g]  <= 1'b0;
        swSel[g] <= 1'b0;
      end else if (wrThis) begin
        swEn[g]  <= busWdata[0] && !NO_DISABLE[g];
        swSel[g] <= busWdata[1];
      end
    end

    assign gateReq[g] = swSel[g] ? (swEn[g] || NO_DISABLE[g]) : hwReq[g];

    ccg_gate #(
      .ON_LAT   (ON_LAT),
      .SHORT_DLY(SHORT_DLY),
      .LONG_DLY (LONG_DLY)
    ) u_gate (
      .clk     (clk),
      .rstN    (rstN),
      .req     (gateReq[g]),
      .hystEn  (hystEn),
      .hystLong(hystLong),
      .clkEn   (clkEn[g]),
      .status  (gateStatus[g])
    );
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == '0) busRdata = {30'b0, violation, accessOpen};
    else if (busAddr == HYST_ADDR) busRdata = {30'b0, hystLong, hystEn};
    for (int i = 0; i < NUM_GATES; i++) begin
      if (busAddr == ADDR_W'(i + 1))
        busRdata = {29'b0, gateStatus[i], swSel[i], swEn[i]};
    end
  end

endmodule

// File: rtl/ccg_bank.sv
module ccg_bank
  import ccg_pkg::*;
#(
  parameter int                   NUM_GATES  = 4,
  parameter int                   ADDR_W     = 4,
  parameter int                   ON_LAT     = 2,
  parameter int                   SHORT_DLY  = 16,
  parameter int                   LONG_DLY   = 64,
  parameter logic [15:0]          PASSWORD   = 16'hA5A5,
  parameter logic [NUM_GATES-1:0] NO_DISABLE = NUM_GATES'(1) << (NUM_GATES - 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_GATES-1:0] hwReq,
  output logic [NUM_GATES-1:0] clkEn,
  output logic [NUM_GATES-1:0] gateStatus
);

  regStrobe_t strobe;
  logic accessOpen, violation;

  ccg_ctrl #(
    .NUM_GATES(NUM_GATES),
    .ADDR_W   (ADDR_W),
    .PASSWORD (PASSWORD)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .strobe    (strobe),
    .accessOpen(accessOpen),
    .violation (violation)
  );

  ccg_regs #(
    .NUM_GATES (NUM_GATES),
    .ADDR_W    (ADDR_W),
    .ON_LAT    (ON_LAT),
    .SHORT_DLY (SHORT_DLY),
    .LONG_DLY  (LONG_DLY),
    .NO_DISABLE(NO_DISABLE)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .accessOpen(accessOpen),
    .violation (violation),
    .hwReq     (hwReq),
    .busRdata  (busRdata),
    .clkEn     (clkEn),
    .gateStatus(gateStatus)
  );

endmodule

// File: rtl/ccg_chk.sv
module ccg_chk #(
  parameter int NUM_GATES = 4,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWr,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 accessOpen,
  input logic                 violation,
  input logic [NUM_GATES-1:0] clkEn,
  input logic [NUM_GATES-1:0] gateStatus
);

  localparam logic [ADDR_W-1:0] HYST_ADDR = ADDR_W'(NUM_GATES + 1);

  // R1
  open_only_by_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == '0) |=> $stable(accessOpen));

  // R3
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);

  // R3
  closed_write_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !accessOpen && busAddr != '0 && busAddr <= HYST_ADDR) |=> violation);

  for (genvar g = 0; g < NUM_GATES; g++) begin : gChk
    // R6
    status_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      gateStatus[g] |-> clkEn[g]);
    // R6
    status_lags_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateStatus[g]) |-> $past(clkEn[g]));
    // R6
    enable_leads_status_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(clkEn[g]) |-> !gateStatus[g]);
    // R8
    fall_together_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(gateStatus[g]) |-> !clkEn[g]);
  end

endmodule

bind ccg_bank ccg_chk #(
  .NUM_GATES(NUM_GATES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .accessOpen(accessOpen),
  .violation (violation),
  .clkEn     (clkEn),
  .gateStatus(gateStatus)
);

// File: tb/ccg_bank_tb.sv
module ccg_bank_tb;

  localparam int NG = 4;
  localparam int AW = 4;
  localparam int ONL = 2;
  localparam int SD = 16;
  localparam int LD = 64;
  localparam logic [NG-1:0] ND = 4'b1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NG-1:0] hwReq = '0;
  logic [NG-1:0] clkEn, gateStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curTag = "R12";

  // reference model state
  bit mOpen, mViol, mHEn, mHLong;
  bit mEn[NG];
  bit mSel[NG];
  int mPhase[NG];  // 0 closed, 1 opening, 2 open, 3 holding
  int mCnt[NG];

  always #4 clk = ~clk;

  ccg_bank #(
    .NUM_GATES(NG), .ADDR_W(AW), .ON_LAT(ONL), .SHORT_DLY(SD),
    .LONG_DLY(LD), .PASSWORD(16'hA5A5), .NO_DISABLE(ND)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hwReq(hwReq),
    .clkEn(clkEn), .gateStatus(gateStatus)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int modelRead(int a);
    if (a == 0) return {mViol, mOpen};
    if (a >= 1 && a <= NG)
      return {(mPhase[a-1] == 2 || mPhase[a-1] == 3), mSel[a-1], mEn[a-1]};
    if (a == NG + 1) return {mHLong, mHEn};
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOpen = 0; mViol = 0; mHEn = 0; mHLong = 0;
      for (int g = 0; g < NG; g++) begin
        mEn[g] = 0; mSel[g] = 0; mPhase[g] = 0; mCnt[g] = 0;
      end
    end else begin
      for (int g = 0; g < NG; g++) begin
        bit req;
        req = mSel[g] ? (mEn[g] | ND[g]) : hwReq[g];
        case (mPhase[g])
          0: if (req) begin mPhase[g] = 1; mCnt[g] = ONL - 1; end
          1: if (!req) mPhase[g] = 0; else if (mCnt[g] == 0) mPhase[g] = 2; else mCnt[g]--;
          2: if (!req) begin
               if (mHEn) begin mPhase[g] = 3; mCnt[g] = (mHLong ? LD : SD) - 1; end
               else mPhase[g] = 0;
             end
          default: if (req) mPhase[g] = 2; else if (mCnt[g] == 0) mPhase[g] = 0; else mCnt[g]--;
        endcase
      end
      if (busWr) begin
        int a;
        a = int'(busAddr);
        if (a == 0) begin
          if (busWdata[23:8] == 16'hA5A5) mOpen = busWdata[0];
          else mViol = 1;
        end else if (a <= NG + 1) begin
          if (!mOpen) mViol = 1;
          else if (a == NG + 1) begin mHEn = busWdata[0]; mHLong = busWdata[1]; end
          else begin mEn[a-1] = busWdata[0] & ~ND[a-1]; mSel[a-1] = busWdata[1]; end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int g = 0; g < NG; g++) begin
        check(curTag, clkEn[g], int'(mPhase[g] != 0));
        check(curTag, gateStatus[g], int'(mPhase[g] == 2 || mPhase[g] == 3));
      end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(int a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = AW'(a); busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readExpect(string tag, int a);
    @(negedge clk);
    busAddr = AW'(a);
    #1;
    check(tag, int'(busRdata), modelRead(a));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    waitCycles(3);
    rstN = 1'b1;
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    // R12 reset state
    @(negedge clk); busAddr = '0; #1;
    check("R12", int'(busRdata), 0);
    busAddr = AW'(1); #1;
    check("R12", int'(busRdata), 0);
    check("R12", int'(clkEn), 0);
    readExpect("R12", NG + 1);

    // R4 bad key at address 0
    curTag = "R4";
    busWrite(0, 32'h00A5A401);
    @(negedge clk); busAddr = '0; #1;
    check("R4", int'(busRdata), 2);
    doReset();

    // R3 write while closed
    curTag = "R3";
    busWrite(2, 32'h3);
    @(negedge clk); busAddr = AW'(2); #1;
    check("R3", int'(busRdata), 0);
    busAddr = '0; #1;
    check("R3", int'(busRdata), 2);
    doReset();

    // R1 open the bank
    curTag = "R1";
    busWrite(0, 32'h00A5A501);
    @(negedge clk); busAddr = '0; #1;
    check("R1", int'(busRdata), 1);

    // R5 hardware source ignores enable bit
    curTag = "R5";
    busWrite(1, 32'h1);
    waitCycles(3);
    check("R5", int'(clkEn[0]), 0);
    hwReq[0] = 1'b1;
    waitCycles(1);
    check("R5", int'(clkEn[0]), 1);
    waitCycles(2);
    check("R5", int'(gateStatus[0]), 1);
    hwReq[0] = 1'b0;
    waitCycles(1);
    check("R5", int'(clkEn[0]), 0);

    // R6 software turn-on timing
    curTag = "R6";
    busWrite(2, 32'h3);
    waitCycles(1);
    check("R6", int'(clkEn[1]), 1);
    check("R6", int'(gateStatus[1]), 0);
    waitCycles(ONL);
    check("R6", int'(gateStatus[1]), 1);
    readExpect("R2", 2);

    // R8 turn-off without hysteresis
    curTag = "R8";
    busWrite(2, 32'h2);
    waitCycles(1);
    check("R8", int'(clkEn[1]), 0);
    check("R8", int'(gateStatus[1]), 0);

    // R9 short hold
    curTag = "R9";
    busWrite(NG + 1, 32'h1);
    readExpect("R9", NG + 1);
    busWrite(2, 32'h3);
    waitCycles(4);
    busWrite(2, 32'h2);
    waitCycles(SD);
    check("R9", int'(clkEn[1]), 1);
    check("R9", int'(gateStatus[1]), 1);
    waitCycles(1);
    check("R9", int'(clkEn[1]), 0);
    check("R9", int'(gateStatus[1]), 0);

    // R10 long hold
    curTag = "R10";
    busWrite(NG + 1, 32'h3);
    busWrite(2, 32'h3);
    waitCycles(4);
    busWrite(2, 32'h2);
    waitCycles(LD);
    check("R10", int'(gateStatus[1]), 1);
    waitCycles(1);
    check("R10", int'(gateStatus[1]), 0);
    check("R10", int'(clkEn[1]), 0);

    // R11 request back during hold, then abort during turn-on
    curTag = "R11";
    busWrite(2, 32'h3);
    waitCycles(4);
    busWrite(2, 32'h2);
    waitCycles(5);
    busWrite(2, 32'h3);
    waitCycles(LD + 4);
    check("R11", int'(gateStatus[1]), 1);
    busWrite(2, 32'h2);
    waitCycles(LD + 3);
    check("R11", int'(clkEn[1]), 0);
    busWrite(2, 32'h3);
    busWrite(2, 32'h2);
    check("R11", int'(gateStatus[1]), 0);
    waitCycles(3);
    check("R11", int'(gateStatus[1]), 0);
    check("R11", int'(clkEn[1]), 0);

    // R7 never-off gate
    curTag = "R7";
    busWrite(NG, 32'h3);
    @(negedge clk); busAddr = AW'(NG); #1;
    check("R7", int'(busRdata[0]), 0);
    waitCycles(4);
    check("R7", int'(clkEn[NG-1]), 1);
    busWrite(NG, 32'h2);
    waitCycles(LD + 4);
    check("R7", int'(clkEn[NG-1]), 1);
    check("R7", int'(gateStatus[NG-1]), 1);

    // R1 close, R2 read while closed, R3 dropped write
    curTag = "R3";
    busWrite(0, 32'h00A5A500);
    @(negedge clk); busAddr = '0; #1;
    check("R1", int'(busRdata), 0);
    readExpect("R2", 2);
    readExpect("R2", 7);
    busWrite(2, 32'h3);
    @(negedge clk); busAddr = AW'(2); #1;
    check("R3", int'(busRdata), 2);
    busAddr = '0; #1;
    check("R3", int'(busRdata), 2);
    busWrite(0, 32'h00A5A501);
    @(negedge clk); busAddr = '0; #1;
    check("R3", int'(busRdata), 3);
    waitCycles(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule